// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block produces four pairs of clock outputs from a fast tick clock. In that tick clock one tick equals one skew time unit. A modulo-N phase counter defines a nominal clock whose period is N ticks. Each output pair shows one of several waveforms: a copy of the nominal clock shifted by a whole number of ticks, a copy divided by two or by four, or an inverted copy. The choice is made by two three-level select codes per pair, which give nine functions per pair. A three-level range code picks N.

A three-level test input takes the phase counter out of the output path. The reference input then drives the outputs directly, and each pair still applies its own function. Select codes and the range code are sampled only when the phase counter wraps. A change made part-way through a period therefore never shortens the current period.

Top module: `skew_clock_matrix`

## Requirements
- R1: Synchronous active-low reset drives every output low and clears the phase counter, the period counter and the bypass divider. The first clock edge after release computes the outputs from phase 0, so a zero-skew pair goes high at that edge.
- R2: Pairs 1 and 2 are nominal outputs. Codes LL, LM, LH, ML, MM, MH, HL, HM and HH shift the rising edge by -4, -3, -2, -1, 0, +1, +2, +3 and +4 ticks. The shift is taken modulo N against a zero-skew pair. The output is high for N/2 ticks, rounded down, with a period of N ticks.
- R3: Pairs 3 and 4 shift by -6, -4, -2, 0, +2, +4 and +6 ticks for codes LM, LH, ML, MM, MH, HL and HM. High time and period are the same as in R2.
- R4: Code LL on pair 3 or pair 4 divides by two. The output is high for N ticks with a 2N period, and it falls at the zero-skew rising edge.
- R5: Code HH on pair 3 divides by four. The output is high for 2N ticks with a 4N period. Each of its falling edges coincides with a falling edge of a divide-by-two output.
- R6: Code HH on pair 4 gives the inverted zero-skew clock. It rises N/2 ticks after the zero-skew rising edge and stays high for N - N/2 ticks, with a period of N.
- R7: Range code LOW, MID or HIGH sets N to 44, 26 or 16 ticks.
- R8: A new select code or range code takes effect only at the next phase-counter wrap. The running period completes with the old setting.
- R9: When the test code is MID or HIGH, any shift code passes the reference input through with one tick of latency and its offset is ignored. The invert code gives the complement of the reference. The divide-by-two code toggles on each rising edge of the reference, and its edges line up with the nominal output's rising edges.
- R10: Both outputs of a pair carry the same waveform at every tick.
- Level encoding on every three-level input: 2'b00 is LOW, 2'b01 is MID, 2'b10 is HIGH, and 2'b11 reads as MID. Pair p (1..4) takes F1 from fsel[4p-1:4p-2] and F0 from fsel[4p-3:4p-4]. The code is named F1 first, then F0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; one period is one skew time unit |
| rst_n | input | 1 | Synchronous active-low reset |
| range_lvl | input | 2 | Range code selecting N |
| test_lvl | input | 2 | Test code; MID or HIGH bypasses the phase counter |
| ref_in | input | 1 | Reference clock used in bypass |
| fsel | input | 16 | Four 4-bit pair codes {F1, F0}; pair 1 in bits 3:0 |
| q0 | output | 4 | First output of each pair; bit p-1 is pair p |
| q1 | output | 4 | Second output of each pair; bit p-1 is pair p |

## Verification
Each of the nine codes is applied to each pair while the other pairs sit at zero skew, under all three N values. The rising-edge distance to a zero-skew neighbour, the high time and the period are measured in ticks. This distinguishes a wrong shift sign, a wrong step size (one tick against two), a wrong modulo wrap for negative shifts, and a swapped divide, invert or shift function. A mixed pattern with divide-by-four next to divide-by-two checks that their falling edges coincide. Two mid-period changes, one of a code and one of the range, show whether the running period is preserved. A toggling reference in bypass checks pass-through, the ignored offset, inversion and reference-driven division.

// File: rtl/skewmat_pkg.sv
`timescale 1ns/1ps
// Shared types and decode for the skew clock matrix.
// Assumes three-level inputs arrive already resolved to two-bit codes.
package skewmat_pkg;

    localparam int NUM_PAIRS = 4;

    typedef enum logic [1:0] {
        FN_NOM  = 2'd0,
        FN_DIV2 = 2'd1,
        FN_DIV4 = 2'd2,
        FN_INV  = 2'd3
    } fn_kind_e;

    // Decoded function of one pair: kind plus a signed tick offset (sign, magnitude)
    typedef struct packed {
        fn_kind_e   kind;
        logic       neg;
        logic [2:0] mag;
    } pair_fn_t;

    // Map a two-bit level to 0 (LOW), 1 (MID) or 2 (HIGH); 2'b11 reads as MID
    function automatic int lvl_idx(input logic [1:0] lvl);
        case (lvl)
            2'b00:   return 0;
            2'b10:   return 2;
            default: return 1;
        endcase
    endfunction

    // Class of a pair: 0 = unit-step shifter, 1 = shifter with /4, 2 = shifter with invert
    function automatic int pair_class(input int idx);
        if (idx < 2)  return 0;
        if (idx == 2) return 1;
        return 2;
    endfunction

    // Decode a {F1,F0} code for a pair of the given class
    function automatic pair_fn_t decode_fn(input logic [3:0] code, input int cls);
        pair_fn_t f;
        int idx;
        idx = 3 * lvl_idx(code[3:2]) + lvl_idx(code[1:0]);
        f.kind = FN_NOM;
        f.neg  = 1'b0;
        f.mag  = 3'd0;
        if (cls == 0) begin
            f.neg = (idx < 4);
            f.mag = (idx < 4) ? 3'(4 - idx) : 3'(idx - 4);
        end else if (idx == 0) begin
            f.kind = FN_DIV2;
        end else if (idx == 8) begin
            f.kind = (cls == 1) ? FN_DIV4 : FN_INV;
        end else begin
            f.neg = (idx < 4);
            f.mag = (idx < 4) ? 3'(8 - 2 * idx) : 3'(2 * idx - 8);
        end
        return f;
    endfunction

endpackage

// File: rtl/skew_phase_ctr.sv
`timescale 1ns/1ps
// Modulo-N phase counter with a period counter for the dividers.
// N is chosen by the range code and is loaded only at reset and at a wrap,
// so a range change never cuts a period short. Assumes N_LO is the largest N.
module skew_phase_ctr #(
    parameter int N_LO = 44,
    parameter int N_MD = 26,
    parameter int N_HI = 16,
    parameter int NW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    range_lvl,
    output logic [NW-1:0] cnt,
    output logic [NW-1:0] n_cur,
    output logic          wrap,
    output logic [1:0]    per_cnt
);

    logic [NW-1:0] n_sel;

    // Translate the range code into a period length in ticks
    always_comb begin
        case (range_lvl)
            2'b00:   n_sel = NW'(N_LO);
            2'b10:   n_sel = NW'(N_HI);
            default: n_sel = NW'(N_MD);
        endcase
    end

    assign wrap = (cnt == n_cur - NW'(1));

    // Advance the phase, reload N and bump the period count at each wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            n_cur   <= n_sel;
            per_cnt <= 2'd0;
        end else if (wrap) begin
            cnt     <= '0;
            n_cur   <= n_sel;
            per_cnt <= per_cnt + 2'd1;
        end else begin
            cnt     <= cnt + NW'(1);
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < n_cur);

    // R8
    n_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(n_cur));

    // R1
    ctr_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && per_cnt == 2'd0));

endmodule

// File: rtl/skew_ref_bypass.sv
`timescale 1ns/1ps
// Reference-driven divider used in test bypass.
// Counts rising edges of the reference and presents the count as it will be
// after this edge, so divided outputs switch on the same tick as a
// pass-through output. Assumes the reference is slow against the tick clock.
module skew_ref_bypass (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    output logic [1:0] bdiv_nxt
);

    logic       ref_d;
    logic [1:0] bcnt;
    logic       ref_rise;

    assign ref_rise = ref_in & ~ref_d;
    assign bdiv_nxt = bcnt + {1'b0, ref_rise};

    // Track the previous reference level and the rising-edge count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_d <= 1'b0;
            bcnt  <= 2'd0;
        end else begin
            ref_d <= ref_in;
            bcnt  <= bdiv_nxt;
        end
    end

    // R9
    bdiv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_in && !ref_d) |=> $stable(bcnt));

endmodule

// File: rtl/skew_pair_unit.sv
`timescale 1ns/1ps
// One output pair. Holds the pair code latched at wrap, turns it into a
// shift, divide or invert function and registers the resulting level on both
// outputs. Assumes cnt < n_cur and that the offset magnitude is below N.
module skew_pair_unit
    import skewmat_pkg::*;
#(
    parameter int PAIR_CLS = 0,
    parameter int NW       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    code,
    input  logic          wrap,
    input  logic [NW-1:0] cnt,
    input  logic [NW-1:0] n_cur,
    input  logic [1:0]    per_cnt,
    input  logic          bypass,
    input  logic          ref_in,
    input  logic [1:0]    bdiv_nxt,
    output logic [1:0]    q
);

    logic [3:0]    code_q;
    pair_fn_t      fn;
    logic [NW-1:0] off_mod;
    logic [NW:0]   diff_w;
    logic          nom_hi;
    logic          q_nxt;
    logic          q_r;

    // Latch the pair code at reset and at each wrap only
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) code_q <= code;
    end

    // Decode the latched code for this pair's class
    always_comb fn = decode_fn(code_q, PAIR_CLS);

    // Place the rising edge modulo N: a negative shift lands at N - k
    always_comb off_mod = fn.neg ? (n_cur - NW'(fn.mag)) : NW'(fn.mag);

    // Distance of the current phase past the rising edge, modulo N
    always_comb begin
        if (cnt >= off_mod) diff_w = {1'b0, cnt} - {1'b0, off_mod};
        else                diff_w = {1'b0, cnt} + {1'b0, n_cur} - {1'b0, off_mod};
    end

    assign nom_hi = diff_w < {1'b0, (n_cur >> 1)};

    // Select the next output level from function and mode
    always_comb begin
        case (fn.kind)
            FN_DIV2: q_nxt = bypass ? bdiv_nxt[0] : per_cnt[0];
            FN_DIV4: q_nxt = bypass ? bdiv_nxt[1] : per_cnt[1];
            FN_INV:  q_nxt = bypass ? ~ref_in     : ~nom_hi;
            default: q_nxt = bypass ? ref_in      : nom_hi;
        endcase
    end

    // Register the output level; reset forces it low
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= 1'b0;
        else        q_r <= q_nxt;
    end

    assign q = {q_r, q_r};

    // R1
    rst_low_chk: assert property (@(posedge clk)
        !rst_n |=> (q_r == 1'b0));

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(code_q));

    // R9
    byp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && fn.kind == FN_NOM) |=> (q_r == $past(ref_in)));

    // R2
    nom_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && fn.kind == FN_NOM && cnt == off_mod) |=> q_r);

endmodule

// File: rtl/skew_clock_matrix.sv
`timescale 1ns/1ps
// Top of the programmable skew clock matrix. It ties one phase counter and
// one bypass divider to four pair units. The pair class, and with it the
// divide-by-four or invert variant, follows the pair index.
// Assumes clk is the time-unit tick and that N_LO is the largest period.
module skew_clock_matrix
    import skewmat_pkg::*;
#(
    parameter int N_LO = 44,
    parameter int N_MD = 26,
    parameter int N_HI = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             range_lvl,
    input  logic [1:0]             test_lvl,
    input  logic                   ref_in,
    input  logic [4*NUM_PAIRS-1:0] fsel,
    output logic [NUM_PAIRS-1:0]   q0,
    output logic [NUM_PAIRS-1:0]   q1
);

    localparam int NW = $clog2(N_LO + 1);

    logic [NW-1:0] cnt;
    logic [NW-1:0] n_cur;
    logic          wrap;
    logic [1:0]    per_cnt;
    logic [1:0]    bdiv_nxt;
    logic          bypass;

    assign bypass = (test_lvl != 2'b00);

    skew_phase_ctr #(
        .N_LO(N_LO), .N_MD(N_MD), .N_HI(N_HI), .NW(NW)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .range_lvl(range_lvl),
        .cnt(cnt), .n_cur(n_cur), .wrap(wrap), .per_cnt(per_cnt)
    );

    skew_ref_bypass u_byp (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .bdiv_nxt(bdiv_nxt)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int CLS = pair_class(p);
        logic [1:0] qp;

        skew_pair_unit #(.PAIR_CLS(CLS), .NW(NW)) u_pair (
            .clk(clk), .rst_n(rst_n), .code(fsel[4*p +: 4]),
            .wrap(wrap), .cnt(cnt), .n_cur(n_cur), .per_cnt(per_cnt),
            .bypass(bypass), .ref_in(ref_in), .bdiv_nxt(bdiv_nxt),
            .q(qp)
        );

        assign q0[p] = qp[0];
        assign q1[p] = qp[1];
    end

endmodule

// File: tb/skew_clock_matrix_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected pair behaviour, a monitor
// captures the outputs per tick and scores each queued item.
module skew_clock_matrix_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] range_lvl;
    logic [1:0] test_lvl;
    logic       ref_in;
    logic [15:0] fsel;
    logic [3:0] q0;
    logic [3:0] q1;

    always #4 clk = ~clk;

    skew_clock_matrix dut_i (
        .clk(clk), .rst_n(rst_n), .range_lvl(range_lvl), .test_lvl(test_lvl),
        .ref_in(ref_in), .fsel(fsel), .q0(q0), .q1(q1)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    typedef struct {
        int    pair;
        int    kind;   // 0 shift, 1 div2, 2 div4, 3 invert, 4 fall alignment
        int    off;
        int    n;
        int    rp;
        string req;
    } exp_t;

    exp_t sb[$];
    logic [3:0] cap [0:511];
    logic       capref [0:511];
    int         cap_len;
    int         pair_mis;
    event       cap_go, cap_done;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int find_edge(int p, int from, bit rising);
        for (int t = (from < 1 ? 1 : from); t < cap_len; t++) begin
            if (rising && cap[t][p] && !cap[t-1][p]) return t;
            if (!rising && !cap[t][p] && cap[t-1][p]) return t;
        end
        return -1;
    endfunction

    function automatic int md(int a, int n);
        return ((a % n) + n) % n;
    endfunction

    task automatic score(exp_t e);
        int n, rr, r, f, r2;
        n  = e.n;
        rr = find_edge(e.rp, 1, 1'b1);
        if (e.kind == 4) begin
            f = find_edge(e.pair, 1, 1'b0);
            chk(f > 0 && !cap[f][3] && cap[f-1][3], e.req,
                "div4 fall without div2 fall", f, f);
            return;
        end
        r = find_edge(e.pair, 1, 1'b1);
        if (r < 0 || rr < 0) begin
            chk(1'b0, e.req, $sformatf("pair%0d no rising edge", e.pair + 1), r, 0);
            return;
        end
        f  = find_edge(e.pair, r + 1, 1'b0);
        r2 = find_edge(e.pair, r + 1, 1'b1);
        case (e.kind)
            0: begin
                chk(md(r - rr, n) == md(e.off, n), e.req,
                    $sformatf("pair%0d offset n=%0d", e.pair + 1, n), md(r - rr, n), md(e.off, n));
                chk(f - r == n / 2, e.req, $sformatf("pair%0d high ticks n=%0d", e.pair + 1, n), f - r, n / 2);
                chk(r2 - r == n, e.req, $sformatf("pair%0d period n=%0d", e.pair + 1, n), r2 - r, n);
            end
            3: begin
                chk(md(r - rr, n) == n / 2, e.req, $sformatf("invert rise n=%0d", n), md(r - rr, n), n / 2);
                chk(f - r == n - n / 2, e.req, $sformatf("invert high n=%0d", n), f - r, n - n / 2);
                chk(r2 - r == n, e.req, $sformatf("invert period n=%0d", n), r2 - r, n);
            end
            default: begin
                int dv;
                dv = (e.kind == 1) ? 2 : 4;
                chk(f - r == n * dv / 2, e.req, $sformatf("div%0d high n=%0d", dv, n), f - r, n * dv / 2);
                chk(r2 - r == n * dv, e.req, $sformatf("div%0d period n=%0d", dv, n), r2 - r, n * dv);
                chk(md(f - rr, n) == 0, e.req, $sformatf("div%0d fall phase n=%0d", dv, n), md(f - rr, n), 0);
            end
        endcase
    endtask

    // Monitor: capture per tick on falling clock edges, then pop and score
    initial begin
        forever begin
            @(cap_go);
            pair_mis = 0;
            for (int t = 0; t < cap_len; t++) begin
                @(negedge clk);
                cap[t]    = q0;
                capref[t] = ref_in;
                if (q0 !== q1) pair_mis++;
            end
            chk(pair_mis == 0, "R10", "Q0/Q1 differing ticks", pair_mis, 0);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                score(e);
            end
            ->cap_done;
        end
    end

    task automatic run_capture(int len);
        cap_len = len;
        ->cap_go;
        @(cap_done);
    endtask

    // Driver: apply one code to one pair, others at zero skew, queue expectation
    task automatic run_cfg(int p, int i, int n, string rtag);
        exp_t e;
        @(posedge clk); #1;
        fsel = {4{4'b0101}};
        fsel[4*p +: 4] = {2'(i / 3), 2'(i % 3)};
        repeat (2 * n + 4) @(posedge clk);
        e.pair = p; e.n = n; e.rp = (p == 0) ? 1 : 0; e.off = 0;
        if (p < 2) begin
            e.kind = 0; e.off = i - 4; e.req = {"R2,", rtag};
        end else if (i == 0) begin
            e.kind = 1; e.req = {"R4,", rtag};
        end else if (i == 8) begin
            e.kind = (p == 2) ? 2 : 3; e.req = (p == 2) ? {"R5,", rtag} : {"R6,", rtag};
        end else begin
            e.kind = 0; e.off = 2 * (i - 4); e.req = {"R3,", rtag};
        end
        sb.push_back(e);
        #1;
        run_capture(9 * n);
    endtask

    task automatic wait_rise0(output bit got);
        logic prev;
        got = 1'b0;
        @(negedge clk); prev = q0[0];
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (q0[0] && !prev) begin got = 1'b1; return; end
            prev = q0[0];
        end
    endtask

    initial begin
        bit   got;
        logic s [0:80];
        int   mis;
        rst_n = 1'b0; range_lvl = 2'b10; test_lvl = 2'b00; ref_in = 1'b0;
        fsel = {4{4'b0101}};
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(q0 == 4'h0 && q1 == 4'h0, "R1", "outputs in reset", {q1, q0}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(q0 == 4'h0, "R1", "outputs before first edge", q0, 0);
        @(negedge clk);
        chk(q0 == 4'hF, "R1", "zero-skew high from phase 0", q0, 15);

        // Sweep every code on every pair under all three periods
        for (int rs = 0; rs < 3; rs++) begin
            int n;
            string rt;
            @(posedge clk); #1;
            range_lvl = (rs == 0) ? 2'b00 : (rs == 1) ? 2'b01 : 2'b10;
            n  = (rs == 0) ? 44 : (rs == 1) ? 26 : 16;
            rt = "R7";
            repeat (100) @(posedge clk);
            for (int p = 0; p < 4; p++)
                for (int i = 0; i < 9; i++)
                    run_cfg(p, i, n, rt);
        end

        // R5: divide-by-4 falls line up with divide-by-2 falls (n = 16)
        begin
            exp_t e;
            @(posedge clk); #1;
            fsel = {4'b0000, 4'b1010, 4'b0101, 4'b0101};
            repeat (40) @(posedge clk);
            e.pair = 2; e.kind = 4; e.off = 0; e.n = 16; e.rp = 0; e.req = "R5";
            sb.push_back(e);
            #1;
            run_capture(144);
        end

        // R8: code change mid-period keeps the running period (n = 16)
        @(posedge clk); #1 fsel = {4{4'b0101}};
        repeat (40) @(posedge clk);
        wait_rise0(got);
        @(posedge clk); #1 fsel[3:0] = 4'b0100;
        for (int k = 1; k <= 40; k++) begin @(negedge clk); s[k] = q0[0]; end
        chk(got && s[7] && !s[8], "R8", "old fall at +8", int'(s[8]), 0);
        chk(!s[15] && s[16], "R8", "rise at wrap +16", int'(s[16]), 1);
        chk(s[22] && !s[23], "R8", "new fall at +23", int'(s[23]), 0);
        chk(!s[30] && s[31], "R8", "shifted rise at +31", int'(s[31]), 1);

        // R8: range change mid-period keeps the running period
        @(posedge clk); #1 fsel = {4{4'b0101}};
        repeat (40) @(posedge clk);
        wait_rise0(got);
        @(posedge clk); #1 range_lvl = 2'b00;
        for (int k = 1; k <= 64; k++) begin @(negedge clk); s[k > 80 ? 80 : k] = q0[0]; end
        chk(got && !s[15] && s[16], "R8,R7", "old-period rise at +16", int'(s[16]), 1);
        chk(s[37] && !s[38], "R8,R7", "new high of 22 ticks", int'(s[38]), 0);
        chk(!s[59] && s[60], "R8,R7", "new period 44", int'(s[60]), 1);

        // R9: bypass with a toggling reference
        @(posedge clk); #1 fsel = {4'b1010, 4'b0000, 4'b1010, 4'b0101};
        repeat (100) @(posedge clk);
        #1 test_lvl = 2'b01;
        fork
            for (int k = 0; k < 60; k++) begin
                repeat (5) @(posedge clk);
                #1 ref_in = ~ref_in;
            end
        join_none
        repeat (12) @(posedge clk);
        #1 run_capture(100);
        mis = 0;
        for (int t = 1; t < 100; t++) if (cap[t][0] !== capref[t-1]) mis++;
        chk(mis == 0, "R9", "pass-through follows ref", mis, 0);
        mis = 0;
        for (int t = 0; t < 100; t++) if (cap[t][1] !== cap[t][0]) mis++;
        chk(mis == 0, "R9", "offset ignored in bypass", mis, 0);
        mis = 0;
        for (int t = 0; t < 100; t++) if (cap[t][3] !== ~cap[t][0]) mis++;
        chk(mis == 0, "R9", "invert in bypass", mis, 0);
        begin
            int r, r2, f;
            r  = find_edge(2, 1, 1'b1);
            r2 = find_edge(2, r + 1, 1'b1);
            f  = find_edge(2, r + 1, 1'b0);
            chk(r > 0 && r2 - r == 20, "R9", "bypass div2 period", r2 - r, 20);
            chk(f > 0 && cap[f][0] && !cap[f-1][0], "R9", "bypass div2 edge on ref rise", f, f);
        end
        @(posedge clk); #1 test_lvl = 2'b10;
        #1 run_capture(30);
        mis = 0;
        for (int t = 1; t < 30; t++) if (cap[t][0] !== capref[t-1]) mis++;
        chk(mis == 0, "R9", "HIGH test code pass-through", mis, 0);

        // R1: reset during operation
        @(posedge clk); #1 test_lvl = 2'b00; rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(q0 == 4'h0 && q1 == 4'h0, "R1", "outputs after mid-run reset", {q1, q0}, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule